// File: doc/BRIEF.md
# Dual Stack Pointer Register Bank

This block holds the two stack pointers of a processor core, one for supervisor mode and one for user mode, and presents whichever one is active to the execution datapath as address register 7. A supervisor-state input picks the active pointer, but only while a dual-stack enable flag is set. That flag is held inside the block, is written through a small configuration port and is cleared by reset. While the flag is clear the core sees a single legacy stack pointer, which is the supervisor storage, in every mode.

The block also decodes the two privileged instruction words that move a value between the user stack pointer and a general address register. It carries out those moves against an external address register file through a read-address/read-data pair and a write port. When the register named in the instruction is A7 itself, the move is handled inside the block. A move attempted in user mode changes nothing and raises a privilege-violation flag. Raising the trap is the job of the surrounding core.

A debug port reads and writes the pointers as "active" and "other", with no translation to supervisor or user names. Reads throughout the block are combinational. Writes take effect at the next rising clock edge.

Top module: `stack_ptr_bank`

## Requirements
- R1: After reset the dual-stack enable flag is 0 and both pointer stores are 0, so `a7_rdata` and both debug views read 0, and `arf_we` and `priv_viol` are 0.
- R2: While the enable flag is 0, `a7_rdata` and writes to A7 always use the supervisor store, whatever the value of `supervisor`. Toggling `supervisor` does not change `a7_rdata`.
- R3: While the enable flag is 1, `supervisor`=1 makes the supervisor store active and the user store "other", and `supervisor`=0 swaps the two roles.
- R4: `cfg_we`=1 loads `cfg_dual` into the enable flag at the next edge. Nothing else changes the flag except reset.
- R5: `a7_we`=1 writes `a7_wdata` into the active store at the next edge.
- R6: With `insn_valid`=1, an `insn_word` in the range 0x4E60..0x4E67 moves to USP. `arf_raddr` equals `insn_word[2:0]` and the user store takes `arf_rdata` at the next edge. If bits 2:0 are 7, the source is the active A7 instead and `arf_rdata` is ignored.
- R7: With `insn_valid`=1, an `insn_word` in the range 0x4E68..0x4E6F moves from USP. In the same cycle, `arf_we`=1, `arf_waddr`=`insn_word[2:0]` and `arf_wdata` is the user store. If bits 2:0 are 7, `arf_we` stays 0 and the active store takes the user store at the next edge.
- R8: A USP move decoded while `supervisor`=0 writes no register and raises `priv_viol` in that same cycle. `arf_we` and `priv_viol` are never both 1.
- R9: While the enable flag is 0, USP moves still read and write the user store, but `a7_rdata` keeps showing the supervisor store.
- R10: `dbg_rdata` shows the active pointer when `dbg_sel`=0 and the other pointer when `dbg_sel`=1. `dbg_we` writes `dbg_wdata` into the selected one at the next edge.
- R11: When a debug write and a datapath write (A7 write or USP move) target the same store in the same cycle, the debug write wins.
- R12: A move-from-USP into A7 takes priority over `a7_we` in the same cycle. Instruction words outside 0x4E60..0x4E6F, or any word with `insn_valid`=0, change nothing and raise neither `arf_we` nor `priv_viol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| supervisor | input | 1 | Processor supervisor state |
| cfg_we | input | 1 | Load the dual-stack enable flag |
| cfg_dual | input | 1 | New value of the enable flag |
| a7_we | input | 1 | Datapath write to A7 |
| a7_wdata | input | 32 | Datapath write data for A7 |
| a7_rdata | output | 32 | Active A7 value |
| insn_valid | input | 1 | `insn_word` holds an instruction to execute |
| insn_word | input | 16 | Instruction word |
| arf_raddr | output | 3 | Register file read index (source of move-to-USP) |
| arf_rdata | input | 32 | Register file read data |
| arf_we | output | 1 | Register file write enable (move-from-USP) |
| arf_waddr | output | 3 | Register file write index |
| arf_wdata | output | 32 | Register file write data |
| priv_viol | output | 1 | USP move attempted in user mode |
| dbg_sel | input | 1 | Debug view select: 0 active, 1 other |
| dbg_we | input | 1 | Debug write strobe |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data |

## Verification
Reads are combinational, so a wrong pointer store or a wrong enable flag shows on `a7_rdata` and `dbg_rdata` in the first cycle after the faulty edge. The bench therefore reads both views right after every step. A mis-steered write shows up as the value landing in the wrong one of the two views, which only becomes visible when the mode or the enable flag lets the two stores be told apart. For this reason the stimulus toggles the enable flag and the supervisor state around each move. Decode errors show at once on `arf_we` and `priv_viol`, in the same cycle as the instruction.

// File: rtl/stack_ptr_bank.sv
module stack_ptr_bank #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            supervisor,
  input  logic            cfg_we,
  input  logic            cfg_dual,
  input  logic            a7_we,
  input  logic [XLEN-1:0] a7_wdata,
  output logic [XLEN-1:0] a7_rdata,
  input  logic            insn_valid,
  input  logic [15:0]     insn_word,
  output logic [2:0]      arf_raddr,
  input  logic [XLEN-1:0] arf_rdata,
  output logic            arf_we,
  output logic [2:0]      arf_waddr,
  output logic [XLEN-1:0] arf_wdata,
  output logic            priv_viol,
  input  logic            dbg_sel,
  input  logic            dbg_we,
  input  logic [XLEN-1:0] dbg_wdata,
  output logic [XLEN-1:0] dbg_rdata
);

  localparam logic [11:0] USP_MOVE_HI = 12'h4E6;

  logic            dual_q;
  logic [XLEN-1:0] ssp_q, usp_q;

  wire usp_move  = insn_valid && (insn_word[15:4] == USP_MOVE_HI);
  wire mv_to     = usp_move && !insn_word[3] && supervisor;
  wire mv_from   = usp_move &&  insn_word[3] && supervisor;
  wire rn_is_sp  = &insn_word[2:0];
  wire act_ssp   = !dual_q || supervisor;

  wire [XLEN-1:0] oth_sp = act_ssp ? usp_q : ssp_q;

  assign a7_rdata  = act_ssp ? ssp_q : usp_q;
  assign dbg_rdata = dbg_sel ? oth_sp : a7_rdata;
  assign priv_viol = usp_move && !supervisor;
  assign arf_raddr = insn_word[2:0];
  assign arf_waddr = insn_word[2:0];
  assign arf_we    = mv_from && !rn_is_sp;
  assign arf_wdata = usp_q;

  wire            pop_to_a7 = mv_from && rn_is_sp;
  wire            act_we    = pop_to_a7 || a7_we;
  wire [XLEN-1:0] act_d     = pop_to_a7 ? usp_q : a7_wdata;
  wire [XLEN-1:0] usp_mv_d  = rn_is_sp ? a7_rdata : arf_rdata;

  wire dbg_act = dbg_we && !dbg_sel;
  wire dbg_oth = dbg_we &&  dbg_sel;
  wire dbg_ssp = act_ssp ? dbg_act : dbg_oth;
  wire dbg_usp = act_ssp ? dbg_oth : dbg_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dual_q <= 1'b0;
      ssp_q  <= '0;
      usp_q  <= '0;
    end else begin
      if (cfg_we) dual_q <= cfg_dual;

      if (dbg_ssp)                ssp_q <= dbg_wdata;
      else if (act_ssp && act_we) ssp_q <= act_d;

      if (dbg_usp)                 usp_q <= dbg_wdata;
      else if (!act_ssp && act_we) usp_q <= act_d;
      else if (mv_to)              usp_q <= usp_mv_d;
    end
  end

endmodule

module stack_ptr_bank_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            supervisor,
  input logic            cfg_we,
  input logic            a7_we,
  input logic [XLEN-1:0] a7_wdata,
  input logic [XLEN-1:0] a7_rdata,
  input logic            insn_valid,
  input logic [15:0]     insn_word,
  input logic [XLEN-1:0] arf_rdata,
  input logic            arf_we,
  input logic            priv_viol,
  input logic            dbg_sel,
  input logic            dbg_we,
  input logic [XLEN-1:0] dbg_wdata,
  input logic            dual_q,
  input logic [XLEN-1:0] usp_q
);

  AST_LEGACY_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_q && !cfg_we && !dbg_we && !a7_we && !insn_valid) |=> $stable(a7_rdata)); // R2

  AST_A7_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (a7_we && !dbg_we && !insn_valid && !cfg_we) |=>
      (!$stable(supervisor) || a7_rdata == $past(a7_wdata))); // R5

  AST_TO_USP: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && supervisor && insn_word[15:3] == 13'h09CC &&
     insn_word[2:0] != 3'd7 && !dbg_we) |=> usp_q == $past(arf_rdata)); // R6

  AST_PRIV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arf_we, priv_viol})); // R8

  AST_PRIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_viol && !dbg_we && !a7_we) |=> $stable(usp_q)); // R8

  AST_DBG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_we && !dbg_sel && !cfg_we) |=>
      (!$stable(supervisor) || a7_rdata == $past(dbg_wdata))); // R11

endmodule

bind stack_ptr_bank stack_ptr_bank_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .supervisor(supervisor), .cfg_we(cfg_we),
  .a7_we(a7_we), .a7_wdata(a7_wdata), .a7_rdata(a7_rdata),
  .insn_valid(insn_valid), .insn_word(insn_word), .arf_rdata(arf_rdata),
  .arf_we(arf_we), .priv_viol(priv_viol), .dbg_sel(dbg_sel),
  .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .dual_q(dual_q), .usp_q(usp_q)
);

// File: tb/stack_ptr_bank_test.sv
module stack_ptr_bank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        supervisor = 1'b0, cfg_we = 1'b0, cfg_dual = 1'b0;
  logic        a7_we = 1'b0, insn_valid = 1'b0, dbg_sel = 1'b0, dbg_we = 1'b0;
  logic [31:0] a7_wdata = '0, arf_rdata = '0, dbg_wdata = '0;
  logic [15:0] insn_word = '0;
  logic [31:0] a7_rdata, arf_wdata, dbg_rdata;
  logic [2:0]  arf_raddr, arf_waddr;
  logic        arf_we, priv_viol;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  stack_ptr_bank uut (
    .clk(clk), .rst_n(rst_n), .supervisor(supervisor), .cfg_we(cfg_we),
    .cfg_dual(cfg_dual), .a7_we(a7_we), .a7_wdata(a7_wdata), .a7_rdata(a7_rdata),
    .insn_valid(insn_valid), .insn_word(insn_word), .arf_raddr(arf_raddr),
    .arf_rdata(arf_rdata), .arf_we(arf_we), .arf_waddr(arf_waddr),
    .arf_wdata(arf_wdata), .priv_viol(priv_viol), .dbg_sel(dbg_sel),
    .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  typedef struct packed {
    logic        sup, cwe, cv, awe;
    logic [31:0] ad;
    logic        iv;
    logic [15:0] iw;
    logic [31:0] ard;
    logic        dwe, dsel;
    logic [31:0] dd;
    logic        e_awe;
    logic [31:0] e_awd;
    logic        e_pv;
    logic [31:0] e_a7, e_oth;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1,0,0,1,32'h1000,0,16'h0000,32'h0,0,0,32'h0, 0,32'h0,0, 32'h1000,32'h0,    5},  // R5
    '{0,0,0,1,32'h2000,0,16'h0000,32'h0,0,0,32'h0, 0,32'h0,0, 32'h2000,32'h0,    2},  // R2
    '{1,0,0,0,32'h0,1,16'h4E63,32'hA0,0,0,32'h0,   0,32'h0,0, 32'h2000,32'hA0,   9},  // R9 R6
    '{1,0,0,0,32'h0,1,16'h4E6D,32'h0,0,0,32'h0,    1,32'hA0,0,32'h2000,32'hA0,   7},  // R7
    '{1,1,1,0,32'h0,0,16'h0000,32'h0,0,0,32'h0,    0,32'h0,0, 32'h2000,32'hA0,   4},  // R4
    '{0,0,0,0,32'h0,0,16'h0000,32'h0,0,0,32'h0,    0,32'h0,0, 32'hA0,32'h2000,   3},  // R3
    '{0,0,0,1,32'h3000,0,16'h0000,32'h0,0,0,32'h0, 0,32'h0,0, 32'h3000,32'h2000, 5},  // R5
    '{0,0,0,0,32'h0,1,16'h4E61,32'h55,0,0,32'h0,   0,32'h0,1, 32'h3000,32'h2000, 8},  // R8
    '{0,0,0,0,32'h0,1,16'h4E69,32'h0,0,0,32'h0,    0,32'h0,1, 32'h3000,32'h2000, 8},  // R8
    '{1,0,0,1,32'h4000,0,16'h0000,32'h0,0,0,32'h0, 0,32'h0,0, 32'h4000,32'h3000, 3},  // R3
    '{1,0,0,0,32'h0,1,16'h4E67,32'h77,0,0,32'h0,   0,32'h0,0, 32'h4000,32'h4000, 6},  // R6
    '{1,0,0,0,32'h0,0,16'h0000,32'h0,1,1,32'h5000, 0,32'h0,0, 32'h4000,32'h5000, 10}, // R10
    '{1,0,0,1,32'h6666,1,16'h4E6F,32'h0,0,0,32'h0, 0,32'h0,0, 32'h5000,32'h5000, 12}, // R12
    '{1,0,0,1,32'h7000,0,16'h0000,32'h0,1,0,32'h8000,0,32'h0,0, 32'h8000,32'h5000, 11}, // R11
    '{1,0,0,0,32'h0,1,16'h4E70,32'h99,0,0,32'h0,   0,32'h0,0, 32'h8000,32'h5000, 12}, // R12
    '{1,1,0,0,32'h0,0,16'h0000,32'h0,0,0,32'h0,    0,32'h0,0, 32'h8000,32'h5000, 4},  // R4
    '{0,0,0,0,32'h0,0,16'h0000,32'h0,0,0,32'h0,    0,32'h0,0, 32'h8000,32'h5000, 2}   // R2
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle();
    cfg_we = 0; a7_we = 0; insn_valid = 0; dbg_we = 0; dbg_sel = 0;
    a7_wdata = '0; insn_word = '0; arf_rdata = '0; dbg_wdata = '0;
  endtask

  task automatic views(input string rq, input logic [31:0] ea7, input logic [31:0] eoth);
    dbg_sel = 0; #1;
    check(rq, a7_rdata, ea7);
    check(rq, dbg_rdata, ea7);
    dbg_sel = 1; #1;
    check(rq, dbg_rdata, eoth);
    dbg_sel = 0;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1 reset state
    views("R1", 32'h0, 32'h0);
    check("R1", {31'b0, arf_we}, 32'h0);
    check("R1", {31'b0, priv_viol}, 32'h0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      supervisor = VECS[i].sup; cfg_we = VECS[i].cwe; cfg_dual = VECS[i].cv;
      a7_we = VECS[i].awe; a7_wdata = VECS[i].ad; insn_valid = VECS[i].iv;
      insn_word = VECS[i].iw; arf_rdata = VECS[i].ard; dbg_we = VECS[i].dwe;
      dbg_sel = VECS[i].dsel; dbg_wdata = VECS[i].dd;
      #1;
      check($sformatf("R%0d arf_we v%0d", VECS[i].rq, i), {31'b0, arf_we}, {31'b0, VECS[i].e_awe});
      check($sformatf("R%0d priv v%0d", VECS[i].rq, i), {31'b0, priv_viol}, {31'b0, VECS[i].e_pv});
      if (VECS[i].e_awe) begin
        check($sformatf("R%0d arf_wdata v%0d", VECS[i].rq, i), arf_wdata, VECS[i].e_awd);
        check($sformatf("R%0d arf_waddr v%0d", VECS[i].rq, i), {29'b0, arf_waddr}, {29'b0, VECS[i].iw[2:0]});
      end
      if (VECS[i].iv && VECS[i].iw[15:3] == 13'h09CC)
        check($sformatf("R%0d arf_raddr v%0d", VECS[i].rq, i), {29'b0, arf_raddr}, {29'b0, VECS[i].iw[2:0]});
      @(posedge clk);
      @(negedge clk);
      idle();
      views($sformatf("R%0d state v%0d", VECS[i].rq, i), VECS[i].e_a7, VECS[i].e_oth);
    end

    // R11: debug write to other beats move-to-USP (dual on, supervisor)
    @(negedge clk);
    cfg_we = 1; cfg_dual = 1; supervisor = 1;
    @(negedge clk);
    idle();
    insn_valid = 1; insn_word = 16'h4E62; arf_rdata = 32'h11;
    dbg_we = 1; dbg_sel = 1; dbg_wdata = 32'h22;
    @(negedge clk);
    idle();
    views("R11 dbg vs move", 32'h8000, 32'h22);

    // R2: legacy mode toggling supervisor keeps A7
    @(negedge clk);
    cfg_we = 1; cfg_dual = 0;
    @(negedge clk);
    idle(); supervisor = 0; #1;
    check("R2 user legacy", a7_rdata, 32'h8000);
    supervisor = 1; #1;
    check("R2 sup legacy", a7_rdata, 32'h8000);

    // R1: reset mid-run clears flag and stores
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    supervisor = 0;
    views("R1 rereset", 32'h0, 32'h0);
    rst_n = 1;
    @(negedge clk);
    a7_we = 1; a7_wdata = 32'hBEEF;
    @(negedge clk);
    idle(); supervisor = 1; #1;
    check("R1 flag cleared", a7_rdata, 32'hBEEF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule